// File: doc/BRIEF.md
# Low-Power Halt Mode Controller

This block is the power-management state machine of a small microcontroller core. When the core executes its halt instruction it raises a one-cycle strobe. A select bit then picks one of two sleep states. Plain halt stops every clock, the oscillator included. Active halt keeps the oscillator and the timekeeping counter running, so the counter's interrupt can wake the core later. While in active halt the block commands the core to clear its interrupt-disable flag and tells the watchdog not to fire.

A wake event starts a settle period of a fixed number of CPU cycles (4096 by default). During that period the oscillator and CPU clocks run and the peripheral clocks stay gated. When the period ends the peripherals are enabled again. The block then pulses one output that tells the core either to fetch its reset vector or to service the waking interrupt. A wake-cause code records the reason for the most recent wakeup. The CPU, the oscillator and the counter appear here only as enables and requests.

Top module: `halt_pm_ctrl`

## Requirements
- R1: In the run state, a halt strobe with `active_sel`=1 enters active halt: `osc_en`=1, `cpu_en`=0, `per_en`=0. With `active_sel`=0 it enters plain halt: all three enables are 0. The outputs change on the clock edge that samples the strobe.
- R2: For the whole of active halt, `irq_dis_clr` is 1. It is 0 in every other state.
- R3: Active halt is left on `wake_rst`, on `tick_irq`, or on any bit set in `irq_req & irq_mask`. Interrupt requests whose mask bit is 0 have no effect.
- R4: Plain halt is left on `wake_rst`, or on a masked interrupt request while `irq_dis`=0. `tick_irq` has no effect in plain halt. A masked request while `irq_dis`=1 also has no effect.
- R5: `wake_cause` is 2'b01 for a reset request, 2'b10 for the timekeeping tick and 2'b11 for another interrupt. A reset request has priority over any interrupt in the same cycle. The code holds until the next wake event and is 2'b00 after reset.
- R6: After a wake event, `settle_busy` is 1 for exactly DELAY_CYCLES clock cycles. During that time `osc_en`=1, `cpu_en`=1 and `per_en`=0.
- R7: In the first cycle after the settle period, `per_en` returns to 1 and exactly one of the following is 1 for one cycle: `resume_rst` when the cause is 2'b01, otherwise `resume_irq`.
- R8: `wdg_hold` is 1 in active halt and 0 in plain halt and in run.
- R9: If a wake source is already active when a halt is entered, the halt state lasts a single cycle and the settle period begins at the next edge.
- R10: A halt strobe outside the run state has no effect on the enables or on the length of the settle period.
- R11: A reset request during the settle period restarts the full delay and sets the cause to 2'b01.
- R12: After `rst_n` the block is in run: all three enables are 1, `settle_busy`, `irq_dis_clr` and `wdg_hold` are 0, and `wake_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | One-cycle strobe from the halt instruction |
| active_sel | input | 1 | 1 selects active halt, 0 selects plain halt |
| wake_rst | input | 1 | Reset request used as a wake source |
| tick_irq | input | 1 | Timekeeping counter interrupt |
| irq_req | input | N_IRQ | Other interrupt requests |
| irq_mask | input | N_IRQ | Marks which requests may wake the core |
| irq_dis | input | 1 | Current interrupt-disable flag of the core |
| osc_en | output | 1 | Main oscillator enable |
| cpu_en | output | 1 | CPU clock enable |
| per_en | output | 1 | Peripheral clock enable |
| irq_dis_clr | output | 1 | Command to clear the interrupt-disable flag |
| wdg_hold | output | 1 | Watchdog reset suppress |
| settle_busy | output | 1 | High during the wake settle delay |
| resume_rst | output | 1 | One-cycle pulse: fetch the reset vector |
| resume_irq | output | 1 | One-cycle pulse: service the waking interrupt |
| wake_cause | output | 2 | Cause code of the most recent wakeup |

## Verification
A wrong state register shows up at once on the clock enables, because each state has its own pattern of enables. A state stuck in halt leaves `cpu_en` low for good, and a state that leaves the settle period early raises `per_en` before the delay is over. An error in the delay counter shows only at the end of the settle period, as a `settle_busy` window that is not DELAY_CYCLES long, so the bench measures every window to the exact cycle. A cause register that is wrong stays invisible until the resume pulse, where the wrong one of `resume_rst` and `resume_irq` fires.

// File: rtl/halt_pm_pkg.sv
package halt_pm_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_ACT    = 2'd2,
        ST_SETTLE = 2'd3
    } pm_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_RST  = 2'b01,
        CAUSE_TICK = 2'b10,
        CAUSE_IRQ  = 2'b11
    } wake_cause_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic per;
        logic clr;
        logic wdg;
        logic busy;
    } gate_t;

    typedef struct packed {
        pm_state_e   st;
        wake_cause_e cause;
        logic        res_rst;
        logic        res_irq;
    } ctl_t;

endpackage

// File: rtl/halt_pm_wake_detect.sv
module halt_pm_wake_detect
    import halt_pm_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             in_act,
    input  logic             in_plain,
    input  logic             wake_rst,
    input  logic             tick_irq,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_mask,
    input  logic             irq_dis,
    output logic             wake,
    output wake_cause_e      cause
);

    logic src_irq;

    assign src_irq = |(irq_req & irq_mask);

    // Priority: reset request, then tick (active halt only), then masked irq
    always_comb begin
        cause = CAUSE_NONE;
        if (in_act) begin
            if (wake_rst)      cause = CAUSE_RST;
            else if (tick_irq) cause = CAUSE_TICK;
            else if (src_irq)  cause = CAUSE_IRQ;
        end else if (in_plain) begin
            if (wake_rst)                 cause = CAUSE_RST;
            else if (src_irq && !irq_dis) cause = CAUSE_IRQ;
        end
    end

    assign wake = (cause != CAUSE_NONE);

endmodule

// File: rtl/halt_pm_settle_timer.sv
module halt_pm_settle_timer #(
    parameter int DELAY_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    output logic expired
);

    localparam int              CNT_W    = $clog2(DELAY_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (en && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && !load && (cnt_q == '0);

endmodule

// File: rtl/halt_pm_gate_decode.sv
module halt_pm_gate_decode
    import halt_pm_pkg::*;
(
    input  pm_state_e st,
    output gate_t     gate
);

    always_comb begin
        gate = '0;
        unique case (st)
            ST_RUN: begin
                gate.osc = 1'b1;
                gate.cpu = 1'b1;
                gate.per = 1'b1;
            end
            ST_HALT: begin
                gate = '0;
            end
            ST_ACT: begin
                gate.osc = 1'b1;
                gate.clr = 1'b1;
                gate.wdg = 1'b1;
            end
            ST_SETTLE: begin
                gate.osc  = 1'b1;
                gate.cpu  = 1'b1;
                gate.busy = 1'b1;
            end
            default: gate = '0;
        endcase
    end

endmodule

// File: rtl/halt_pm_ctrl.sv
module halt_pm_ctrl
    import halt_pm_pkg::*;
#(
    parameter int N_IRQ        = 8,
    parameter int DELAY_CYCLES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             active_sel,
    input  logic             wake_rst,
    input  logic             tick_irq,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_mask,
    input  logic             irq_dis,
    output logic             osc_en,
    output logic             cpu_en,
    output logic             per_en,
    output logic             irq_dis_clr,
    output logic             wdg_hold,
    output logic             settle_busy,
    output logic             resume_rst,
    output logic             resume_irq,
    output logic [1:0]       wake_cause
);

    ctl_t        ctl_d, ctl_q;
    logic        wake;
    wake_cause_e det_cause;
    logic        tmr_load;
    logic        tmr_expired;
    gate_t       gate;

    halt_pm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .in_act   (ctl_q.st == ST_ACT),
        .in_plain (ctl_q.st == ST_HALT),
        .wake_rst (wake_rst),
        .tick_irq (tick_irq),
        .irq_req  (irq_req),
        .irq_mask (irq_mask),
        .irq_dis  (irq_dis),
        .wake     (wake),
        .cause    (det_cause)
    );

    halt_pm_settle_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .en      (ctl_q.st == ST_SETTLE),
        .expired (tmr_expired)
    );

    halt_pm_gate_decode u_gate (
        .st   (ctl_q.st),
        .gate (gate)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.res_rst = 1'b0;
        ctl_d.res_irq = 1'b0;
        tmr_load      = 1'b0;
        unique case (ctl_q.st)
            ST_RUN: begin
                if (halt_req)
                    ctl_d.st = active_sel ? ST_ACT : ST_HALT;
            end
            ST_HALT, ST_ACT: begin
                if (wake) begin
                    ctl_d.st    = ST_SETTLE;
                    ctl_d.cause = det_cause;
                    tmr_load    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (wake_rst) begin
                    ctl_d.cause = CAUSE_RST;
                    tmr_load    = 1'b1;
                end else if (tmr_expired) begin
                    ctl_d.st      = ST_RUN;
                    ctl_d.res_rst = (ctl_q.cause == CAUSE_RST);
                    ctl_d.res_irq = (ctl_q.cause != CAUSE_RST);
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_RUN;
            ctl_q.cause   <= CAUSE_NONE;
            ctl_q.res_rst <= 1'b0;
            ctl_q.res_irq <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign osc_en      = gate.osc;
    assign cpu_en      = gate.cpu;
    assign per_en      = gate.per;
    assign irq_dis_clr = gate.clr;
    assign wdg_hold    = gate.wdg;
    assign settle_busy = gate.busy;
    assign resume_rst  = ctl_q.res_rst;
    assign resume_irq  = ctl_q.res_irq;
    assign wake_cause  = ctl_q.cause;

endmodule

// File: rtl/halt_pm_ctrl_chk.sv
module halt_pm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic       active_sel,
    input logic       wake_rst,
    input logic       tick_irq,
    input logic       osc_en,
    input logic       cpu_en,
    input logic       per_en,
    input logic       irq_dis_clr,
    input logic       wdg_hold,
    input logic       settle_busy,
    input logic       resume_rst,
    input logic       resume_irq,
    input logic [1:0] wake_cause
);

    p_enter_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && per_en && halt_req && active_sel)
        |=> (osc_en && !cpu_en && !per_en && irq_dis_clr));

    p_enter_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && per_en && halt_req && !active_sel)
        |=> (!osc_en && !cpu_en && !per_en));

    p_wdg_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && per_en && halt_req) |=> (wdg_hold == $past(active_sel)));

    p_tick_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !cpu_en && tick_irq && !wake_rst)
        |=> (settle_busy && wake_cause == 2'b10));

    p_rst_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_en && wake_rst) |=> (settle_busy && wake_cause == 2'b01));

    p_settle_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_busy && wake_rst) |=> (settle_busy && wake_cause == 2'b01));

    p_resume_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_rst || resume_irq) |-> ($past(settle_busy) && per_en));

    p_resume_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_rst, resume_irq}));

    p_resume_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_rst |-> (wake_cause == 2'b01));

endmodule

bind halt_pm_ctrl halt_pm_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .active_sel  (active_sel),
    .wake_rst    (wake_rst),
    .tick_irq    (tick_irq),
    .osc_en      (osc_en),
    .cpu_en      (cpu_en),
    .per_en      (per_en),
    .irq_dis_clr (irq_dis_clr),
    .wdg_hold    (wdg_hold),
    .settle_busy (settle_busy),
    .resume_rst  (resume_rst),
    .resume_irq  (resume_irq),
    .wake_cause  (wake_cause)
);

// File: tb/halt_pm_ctrl_tb.sv
module halt_pm_ctrl_tb;

    localparam int N_IRQ = 8;
    localparam int DELAY = 4096;
    localparam logic [N_IRQ-1:0] MASK     = 8'b0000_0101;
    localparam logic [N_IRQ-1:0] IRQ_MSKD = 8'b0000_0100;
    localparam logic [N_IRQ-1:0] IRQ_UNMS = 8'b0000_0010;

    // src: 0 reset request, 1 tick, 2 masked irq, 3 ignored source then masked irq
    typedef struct packed {
        logic       act;
        logic [1:0] src;
        logic [1:0] cause;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 2'd0, 2'b01},
        '{1'b1, 2'd1, 2'b10},
        '{1'b1, 2'd2, 2'b11},
        '{1'b0, 2'd0, 2'b01},
        '{1'b0, 2'd2, 2'b11},
        '{1'b0, 2'd3, 2'b11},
        '{1'b1, 2'd3, 2'b11}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             halt_req = 1'b0;
    logic             active_sel = 1'b0;
    logic             wake_rst = 1'b0;
    logic             tick_irq = 1'b0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_mask = MASK;
    logic             irq_dis = 1'b0;
    logic             osc_en, cpu_en, per_en, irq_dis_clr, wdg_hold;
    logic             settle_busy, resume_rst, resume_irq;
    logic [1:0]       wake_cause;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    halt_pm_ctrl #(.N_IRQ(N_IRQ), .DELAY_CYCLES(DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .active_sel(active_sel),
        .wake_rst(wake_rst), .tick_irq(tick_irq), .irq_req(irq_req),
        .irq_mask(irq_mask), .irq_dis(irq_dis), .osc_en(osc_en), .cpu_en(cpu_en),
        .per_en(per_en), .irq_dis_clr(irq_dis_clr), .wdg_hold(wdg_hold),
        .settle_busy(settle_busy), .resume_rst(resume_rst), .resume_irq(resume_irq),
        .wake_cause(wake_cause)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_chk++;
        if (actual !== expected) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic strobe(input logic sel);
        @(negedge clk);
        active_sel = sel;
        halt_req   = 1'b1;
        @(negedge clk);
        halt_req   = 1'b0;
    endtask

    // Called at a negedge with settle_busy high; returns busy cycle count
    task automatic measure_settle(output int n);
        n = 0;
        while (settle_busy && n < 3 * DELAY) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_and_check(input string tag, input logic is_rst);
        int n;
        measure_settle(n);
        chk({tag, " R6 settle length"}, n, DELAY);
        chk({tag, " R7 per_en back"}, per_en, 1);
        chk({tag, " R7 resume_rst"}, resume_rst, is_rst);
        chk({tag, " R7 resume_irq"}, resume_irq, !is_rst);
        @(negedge clk);
        chk({tag, " R7 pulse one cycle"}, {resume_rst, resume_irq}, 0);
    endtask

    task automatic run_vec(input vec_t v);
        strobe(v.act);
        chk("R1 osc_en in halt", osc_en, v.act);
        chk("R1 cpu_en in halt", cpu_en, 0);
        chk("R1 per_en in halt", per_en, 0);
        chk("R2 irq_dis_clr", irq_dis_clr, v.act);
        chk("R8 wdg_hold", wdg_hold, v.act);
        if (v.src == 2'd3) begin
            if (v.act) irq_req = IRQ_UNMS;
            else       tick_irq = 1'b1;
            @(negedge clk);
            irq_req  = '0;
            tick_irq = 1'b0;
            @(negedge clk);
            chk(v.act ? "R3 unmasked irq ignored" : "R4 tick ignored in plain halt",
                {settle_busy, cpu_en}, 0);
        end
        case (v.src)
            2'd0:    wake_rst = 1'b1;
            2'd1:    tick_irq = 1'b1;
            default: irq_req  = IRQ_MSKD;
        endcase
        @(negedge clk);
        wake_rst = 1'b0;
        tick_irq = 1'b0;
        irq_req  = '0;
        chk("R3 R4 wake to settle", settle_busy, 1);
        chk("R6 gates in settle", {osc_en, cpu_en, per_en}, 3'b110);
        chk("R5 wake_cause", wake_cause, v.cause);
        finish_and_check("vec", v.cause == 2'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 enables", {osc_en, cpu_en, per_en}, 3'b111);
        chk("R12 flags", {settle_busy, irq_dis_clr, wdg_hold, resume_rst, resume_irq}, 0);
        chk("R12 wake_cause", wake_cause, 0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R5 reset request beats tick in the same cycle
        strobe(1'b1);
        wake_rst = 1'b1;
        tick_irq = 1'b1;
        @(negedge clk);
        wake_rst = 1'b0;
        tick_irq = 1'b0;
        chk("R5 reset priority cause", wake_cause, 2'b01);
        finish_and_check("R5", 1'b1);

        // R9 request pending at entry: halt lasts one cycle
        irq_req = IRQ_MSKD;
        strobe(1'b1);
        chk("R9 halt entered", {cpu_en, irq_dis_clr, settle_busy}, 3'b010);
        @(negedge clk);
        irq_req = '0;
        chk("R9 immediate settle", settle_busy, 1);
        chk("R9 cause", wake_cause, 2'b11);
        finish_and_check("R9", 1'b0);

        // R4 masked irq blocked in plain halt while irq_dis=1
        irq_dis = 1'b1;
        strobe(1'b0);
        irq_req = IRQ_MSKD;
        repeat (3) @(negedge clk);
        chk("R4 irq_dis blocks wake", {settle_busy, osc_en}, 0);
        // R10 strobe during halt ignored
        active_sel = 1'b1;
        halt_req   = 1'b1;
        @(negedge clk);
        halt_req   = 1'b0;
        chk("R10 strobe in halt ignored", {osc_en, wdg_hold, settle_busy}, 0);
        irq_dis = 1'b0;
        @(negedge clk);
        irq_req = '0;
        chk("R4 wake once irq_dis clear", settle_busy, 1);
        chk("R4 cause", wake_cause, 2'b11);
        // R10 strobe during settle ignored
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        begin
            int n;
            measure_settle(n);
            chk("R10 settle length unchanged", n, DELAY - 1);
        end
        chk("R10 resume_irq", resume_irq, 1);
        repeat (3) @(negedge clk);
        chk("R10 still running", {cpu_en, per_en, settle_busy}, 3'b110);

        // R11 reset request in settle restarts the delay
        strobe(1'b1);
        tick_irq = 1'b1;
        @(negedge clk);
        tick_irq = 1'b0;
        chk("R11 tick cause before restart", wake_cause, 2'b10);
        repeat (100) @(negedge clk);
        wake_rst = 1'b1;
        @(negedge clk);
        wake_rst = 1'b0;
        chk("R11 cause after restart", wake_cause, 2'b01);
        finish_and_check("R11", 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule